// File: doc/BRIEF.md
# Auto-Negotiation Priority Resolver

This block sits behind a link-pulse demodulator in an Ethernet PHY. It receives 16-bit link code words that have already been recovered from fast link pulse bursts. It also receives two parallel-detect flags: one for 100BASE-TX idle and one for 10BASE-T normal link pulses. From these inputs it decides when the partner's advertised abilities can be trusted, stores them, and resolves the operating speed and duplex that both ends share.

The block trusts a partner word only after a run of three identical words. The acknowledge bit is left out of that comparison. The block then waits for a second run of three before it resolves. If the partner sends only idle symbols or normal link pulses, the speed follows the detected line type. Negotiation is held off in fiber mode or while it is disabled. It starts again on reset, on loss of link, or on a restart request.

Top module: `an_resolve_top`

## Requirements
- R1: After synchronous reset, an_done, no_common, res_speed100, res_full and partner_word are all 0.
- R2: A strobed word continues the current run only when it equals the previous strobed word with bit 14 (acknowledge) masked. Any other difference starts a new run of length one.
- R3: When a run reaches three words, partner_word takes the third word exactly as received, two clock edges after that word is sampled, while an_done stays 0.
- R4: A second run of three words, with any content, resolves the mode. It sets an_done two edges after its third word and loads that word into partner_word.
- R5: The common set is local_adv[8:5] AND partner[8:5], where bit 8 means 100 full, bit 7 means 100 half, bit 6 means 10 full and bit 5 means 10 half. The highest set bit is chosen. res_speed100=1 means 100 Mb/s and res_full=1 means full duplex.
- R6: If the common set is empty, no_common goes to 1 and an_done, res_speed100 and res_full stay 0.
- R7: Before resolution, pd_tx_idle resolves to 100 half duplex and pd_nlp resolves to 10 half duplex, one edge after the flag is sampled. pd_tx_idle wins when both flags are high. A completed code-word run in the same cycle takes precedence over either flag.
- R8: an_restart or link_lost clears all outputs and restarts collection from an empty run.
- R9: While fiber_mode is 1 or an_enable is 0, all outputs stay 0 and both code words and parallel-detect flags are ignored.
- R10: Once resolved, further code words and parallel-detect flags change no output until a restart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| an_enable | input | 1 | Negotiation enable |
| an_restart | input | 1 | Restart request, one cycle |
| link_lost | input | 1 | Link loss indication |
| fiber_mode | input | 1 | Fiber operation; disables negotiation |
| local_adv | input | 16 | Local advertisement word |
| cw_valid | input | 1 | Code word strobe |
| cw_data | input | 16 | Received code word |
| pd_tx_idle | input | 1 | 100BASE-TX idle detected |
| pd_nlp | input | 1 | 10BASE-T normal link pulses detected |
| res_speed100 | output | 1 | Resolved speed: 1 = 100 Mb/s |
| res_full | output | 1 | Resolved duplex: 1 = full |
| an_done | output | 1 | Resolution complete |
| no_common | output | 1 | No shared ability |
| partner_word | output | 16 | Stored partner code word |

## Verification
The core of the bench is a sweep over all 256 pairings of local and partner ability nibbles. After the first run, each pairing checks the stored word and the still-low done flag. The second run sends its words with the acknowledge bit set, so the sweep also confirms that acknowledge is masked. The final outputs of each pairing separate every priority level from the next and separate the empty-intersection case from a resolved one. Directed sequences cover the remaining corners:
- a run broken by a differing word;
- each parallel-detect flag alone and both together;
- strobes after resolution;
- restart and link loss;
- fiber and disabled operation.

// File: rtl/an_pkg.sv
package an_pkg;
  typedef enum logic [2:0] {
    ST_OFF,
    ST_RUN1,
    ST_RUN2,
    ST_DONE,
    ST_NOMATCH
  } an_state_t;
endpackage

// File: rtl/an_run_matcher.sv
module an_run_matcher #(
  parameter int WORD_W  = 16,
  parameter int ACK_BIT = 14,
  parameter int MATCH_N = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              clr,
  input  logic              cw_valid,
  input  logic [WORD_W-1:0] cw_data,
  output logic              hit,
  output logic [WORD_W-1:0] hit_word
);
  localparam int CNT_W = $clog2(MATCH_N + 1);
  localparam logic [WORD_W-1:0] ACK_MASK =
    ~({{(WORD_W-1){1'b0}}, 1'b1} << ACK_BIT);

  logic [WORD_W-1:0] last_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [CNT_W-1:0]  cnt_nx;
  logic              same;

  assign same = (cnt_q != '0) && ((cw_data & ACK_MASK) == (last_q & ACK_MASK));

  always_comb begin
    cnt_nx = same ? cnt_q + CNT_W'(1) : CNT_W'(1);
  end

  always_ff @(posedge clk) begin
    if (rst || clr) begin
      cnt_q    <= '0;
      last_q   <= '0;
      hit      <= 1'b0;
      hit_word <= '0;
    end else begin
      hit <= 1'b0;
      if (cw_valid) begin
        last_q <= cw_data;
        if (cnt_nx == CNT_W'(MATCH_N)) begin
          cnt_q    <= '0;
          hit      <= 1'b1;
          hit_word <= cw_data;
        end else begin
          cnt_q <= cnt_nx;
        end
      end
    end
  end

  // R3: a completed run is always caused by a strobe on the previous edge
  p_hit_from_strobe_r3: assert property (@(posedge clk) disable iff (rst)
    hit |-> $past(cw_valid));
  // R2: the run length never exceeds the match length
  p_run_bound_r2: assert property (@(posedge clk) disable iff (rst)
    cnt_q < CNT_W'(MATCH_N));
endmodule

// File: rtl/an_prio_pick.sv
module an_prio_pick #(
  parameter int ABIL_N = 4
) (
  input  logic [ABIL_N-1:0] local_abil,
  input  logic [ABIL_N-1:0] peer_abil,
  output logic              found,
  output logic              speed100,
  output logic              full
);
  localparam int IDX_W = $clog2(ABIL_N);

  logic [ABIL_N-1:0] common;
  logic [IDX_W-1:0]  idx;

  assign common = local_abil & peer_abil;

  always_comb begin
    found = 1'b0;
    idx   = '0;
    for (int i = 0; i < ABIL_N; i++) begin
      if (common[i]) begin
        found = 1'b1;
        idx   = IDX_W'(i);
      end
    end
    speed100 = found && (idx >= IDX_W'(ABIL_N / 2));
    full     = found && idx[0];
  end
endmodule

// File: rtl/an_resolve_top.sv
module an_resolve_top #(
  parameter int WORD_W   = 16,
  parameter int ACK_BIT  = 14,
  parameter int MATCH_N  = 3,
  parameter int ABIL_LSB = 5,
  parameter int ABIL_N   = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              an_enable,
  input  logic              an_restart,
  input  logic              link_lost,
  input  logic              fiber_mode,
  input  logic [WORD_W-1:0] local_adv,
  input  logic              cw_valid,
  input  logic [WORD_W-1:0] cw_data,
  input  logic              pd_tx_idle,
  input  logic              pd_nlp,
  output logic              res_speed100,
  output logic              res_full,
  output logic              an_done,
  output logic              no_common,
  output logic [WORD_W-1:0] partner_word
);
  import an_pkg::*;

  an_state_t         state_q;
  logic              hold;
  logic              restart;
  logic              collecting;
  logic              m_clr;
  logic              m_hit;
  logic [WORD_W-1:0] m_word;
  logic              p_found;
  logic              p_speed;
  logic              p_full;

  assign hold       = !an_enable || fiber_mode;
  assign restart    = an_restart || link_lost;
  assign collecting = (state_q == ST_RUN1) || (state_q == ST_RUN2);
  assign m_clr      = hold || restart || !collecting;

  an_run_matcher #(
    .WORD_W (WORD_W),
    .ACK_BIT(ACK_BIT),
    .MATCH_N(MATCH_N)
  ) u_match (
    .clk     (clk),
    .rst     (rst),
    .clr     (m_clr),
    .cw_valid(cw_valid),
    .cw_data (cw_data),
    .hit     (m_hit),
    .hit_word(m_word)
  );

  an_prio_pick #(
    .ABIL_N(ABIL_N)
  ) u_pick (
    .local_abil(local_adv[ABIL_LSB +: ABIL_N]),
    .peer_abil (m_word[ABIL_LSB +: ABIL_N]),
    .found     (p_found),
    .speed100  (p_speed),
    .full      (p_full)
  );

  always_ff @(posedge clk) begin
    if (rst || hold || restart) begin
      state_q      <= (rst || hold) ? ST_OFF : ST_RUN1;
      res_speed100 <= 1'b0;
      res_full     <= 1'b0;
      an_done      <= 1'b0;
      no_common    <= 1'b0;
      partner_word <= '0;
    end else begin
      case (state_q)
        ST_OFF: state_q <= ST_RUN1;
        ST_RUN1, ST_RUN2: begin
          if (m_hit) begin
            partner_word <= m_word;
            if (state_q == ST_RUN1) begin
              state_q <= ST_RUN2;
            end else if (p_found) begin
              state_q      <= ST_DONE;
              an_done      <= 1'b1;
              res_speed100 <= p_speed;
              res_full     <= p_full;
            end else begin
              state_q   <= ST_NOMATCH;
              no_common <= 1'b1;
            end
          end else if (pd_tx_idle || pd_nlp) begin
            state_q      <= ST_DONE;
            an_done      <= 1'b1;
            res_speed100 <= pd_tx_idle;
            res_full     <= 1'b0;
          end
        end
        default: state_q <= state_q;
      endcase
    end
  end

  // R9: held off in fiber mode or when disabled
  p_hold_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (fiber_mode || !an_enable) |=> (!an_done && !no_common && partner_word == '0));
  // R8: restart or link loss empties the result
  p_restart_clears_r8: assert property (@(posedge clk) disable iff (rst)
    (an_restart || link_lost) |=> (!an_done && partner_word == '0));
  // R6: done and no-common never coexist, and no mode is reported without a match
  p_excl_r6: assert property (@(posedge clk) disable iff (rst)
    no_common |-> (!an_done && !res_speed100 && !res_full));
  // R10: a resolved mode holds until restart
  p_done_holds_r10: assert property (@(posedge clk) disable iff (rst)
    (an_done && !an_restart && !link_lost && an_enable && !fiber_mode)
      |=> (an_done && $stable(res_speed100) && $stable(res_full)
           && $stable(partner_word)));
  // R7: parallel detection never yields full duplex from idle state
  p_pd_half_r7: assert property (@(posedge clk) disable iff (rst)
    ($rose(an_done) && $stable(partner_word) && $past(state_q) == ST_RUN1)
      |-> !res_full);
endmodule

// File: tb/tb_an_resolve_top.sv
module tb_an_resolve_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        an_enable = 1'b1;
  logic        an_restart = 1'b0;
  logic        link_lost = 1'b0;
  logic        fiber_mode = 1'b0;
  logic [15:0] local_adv = '0;
  logic        cw_valid = 1'b0;
  logic [15:0] cw_data = '0;
  logic        pd_tx_idle = 1'b0;
  logic        pd_nlp = 1'b0;
  logic        res_speed100, res_full, an_done, no_common;
  logic [15:0] partner_word;

  int checks = 0;
  int fails = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  an_resolve_top dut (
    .clk(clk), .rst(rst), .an_enable(an_enable), .an_restart(an_restart),
    .link_lost(link_lost), .fiber_mode(fiber_mode), .local_adv(local_adv),
    .cw_valid(cw_valid), .cw_data(cw_data), .pd_tx_idle(pd_tx_idle),
    .pd_nlp(pd_nlp), .res_speed100(res_speed100), .res_full(res_full),
    .an_done(an_done), .no_common(no_common), .partner_word(partner_word)
  );

  function automatic logic [19:0] outs();
    return {an_done, no_common, res_speed100, res_full, partner_word};
  endfunction

  function automatic logic [19:0] pack(input logic d, input logic n,
                                       input logic s, input logic f,
                                       input logic [15:0] w);
    return {d, n, s, f, w};
  endfunction

  // expected {done,nocommon,speed,full} from ability nibbles {100F,100H,10F,10H}
  function automatic logic [3:0] expect_mode(input logic [3:0] la,
                                             input logic [3:0] pa);
    logic [3:0] c;
    c = la & pa;
    if (c[3]) return 4'b1011;
    if (c[2]) return 4'b1010;
    if (c[1]) return 4'b1001;
    if (c[0]) return 4'b1000;
    return 4'b0100;
  endfunction

  task automatic check(input string req, input logic [19:0] exp);
    checks++;
    if (outs() !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, outs(), exp);
    end
  endtask

  task automatic send_word(input logic [15:0] w);
    @(negedge clk);
    cw_valid = 1'b1;
    cw_data  = w;
    @(negedge clk);
    cw_valid = 1'b0;
  endtask

  task automatic send_run(input logic [15:0] w);
    for (int k = 0; k < 3; k++) send_word(w);
    @(negedge clk);
  endtask

  task automatic pulse_restart();
    @(negedge clk);
    an_restart = 1'b1;
    @(negedge clk);
    an_restart = 1'b0;
  endtask

  task automatic pulse_pd(input logic tx, input logic nlp);
    @(negedge clk);
    pd_tx_idle = tx;
    pd_nlp     = nlp;
    @(negedge clk);
    pd_tx_idle = 1'b0;
    pd_nlp     = 1'b0;
  endtask

  initial begin
    #(5.0 * 190000);
    if (!finished) begin
      fails++;
      checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [15:0] w1, w2;
    logic [3:0]  m;
    repeat (3) @(negedge clk);
    check("R1 reset state", 20'h0);
    rst = 1'b0;
    repeat (2) @(negedge clk);

    // R5 R6 R3 R4 R2: exhaustive ability sweep, ack set on second run
    for (int la = 0; la < 16; la++) begin
      for (int pa = 0; pa < 16; pa++) begin
        pulse_restart();
        local_adv = {7'd0, 4'(la), 5'd1};
        w1 = {7'd0, 4'(pa), 5'd1};
        w2 = w1 | 16'h4000;
        send_run(w1);
        check("R3 first run stored, not done", pack(0, 0, 0, 0, w1));
        send_word(w1);
        send_word(w2);
        send_word(w1);
        @(negedge clk);
        m = expect_mode(4'(la), 4'(pa));
        check("R5/R6 R4 R2 resolved mode", {m, w1});
      end
    end

    // R2: a differing word breaks the run
    local_adv = 16'h01E1;
    pulse_restart();
    send_word(16'h0121);
    send_word(16'h0121);
    send_word(16'h0041);
    send_word(16'h0121);
    send_word(16'h0121);
    @(negedge clk);
    check("R2 broken run not stored", 20'h0);
    send_word(16'h0121);
    @(negedge clk);
    check("R2 R3 run completes after restart of count", pack(0, 0, 0, 0, 16'h0121));

    // R7: parallel detection
    pulse_restart();
    pulse_pd(1, 0);
    check("R7 tx idle gives 100 half", pack(1, 0, 1, 0, 16'h0));
    pulse_restart();
    pulse_pd(0, 1);
    check("R7 nlp gives 10 half", pack(1, 0, 0, 0, 16'h0));
    pulse_restart();
    pulse_pd(1, 1);
    check("R7 tx idle wins", pack(1, 0, 1, 0, 16'h0));
    pulse_restart();
    send_run(16'h0121);
    pulse_pd(0, 1);
    check("R7 pd after first run keeps word", pack(1, 0, 0, 0, 16'h0121));

    // R10: ignore after resolution
    pulse_pd(1, 0);
    check("R10 pd ignored after done", pack(1, 0, 0, 0, 16'h0121));
    send_run(16'h0161);
    send_run(16'h0161);
    check("R10 words ignored after done", pack(1, 0, 0, 0, 16'h0121));

    // R8: link loss clears
    @(negedge clk);
    link_lost = 1'b1;
    @(negedge clk);
    link_lost = 1'b0;
    check("R8 link loss clears", 20'h0);
    send_run(16'h0101);
    send_run(16'h0101);
    check("R8 R5 renegotiates after link loss", pack(1, 0, 1, 1, 16'h0101));
    pulse_restart();
    check("R8 restart clears", 20'h0);

    // R9: fiber mode and disable
    fiber_mode = 1'b1;
    send_run(16'h0101);
    send_run(16'h0101);
    pulse_pd(1, 0);
    check("R9 fiber mode ignores input", 20'h0);
    fiber_mode = 1'b0;
    an_enable  = 1'b0;
    send_run(16'h0101);
    send_run(16'h0101);
    pulse_pd(0, 1);
    check("R9 disabled ignores input", 20'h0);
    an_enable = 1'b1;
    repeat (2) @(negedge clk);
    send_run(16'h0041);
    send_run(16'h0041);
    check("R9 R5 resumes after enable", pack(1, 0, 0, 1, 16'h0041));

    finished = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule